// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the command-word front end of an eight-line programmable interrupt controller. A processor reaches it through active-low select, write and read strobes, one address bit and an 8-bit data bus. Each write strobe is turned into a single action in the clock domain, on the first clock edge at which select and write are both low. The block runs the start-up sequence of two to four setup words. After that sequence it takes run-time commands at any time: mask loads, read-back selection, special-mask control and end-of-interrupt.

The programmed values go to the controller core as plain outputs. These are the mask, the vector base, the trigger mode, the auto-EOI flag, the cascade flag, the special-mask flag and the lowest-priority line. The block also produces two one-cycle pulses: a pulse that re-arms edge detection, and a one-hot pulse telling the core which in-service bit to clear. The core supplies its pending and in-service registers, and the block returns one of them, or the mask, on reads.

Top module: `irq_cmd_port`

## Requirements
- R1: After reset, cfg_ready, irq_mask, vec_base, level_mode, auto_eoi, cascaded, special_mask, edge_rearm and eoi_clear are all 0. lowest_line is 7, and address-0 reads return req_pending.
- R2: While cs_n is high, writes change nothing and rdata is 0.
- R3: A write with addr=0 and wdata[4]=1 restarts setup from any state. At the following edge cfg_ready falls, irq_mask and special_mask clear, read-back selects req_pending and lowest_line becomes 7. edge_rearm is high for exactly one cycle.
- R4: The setup restart word sets level_mode from wdata[3]. The next addr=1 write loads vec_base from wdata[7:3].
- R5: cascaded equals the inverse of wdata[1] of the restart word. A third addr=1 setup word is consumed only when cascaded is 1.
- R6: A fourth addr=1 setup word is expected only when wdata[0] of the restart word was 1. That word sets auto_eoi from its wdata[1]. Otherwise auto_eoi stays 0.
- R7: cfg_ready rises after the last expected setup word. Only while cfg_ready is 1 does an addr=1 write load irq_mask, and only then do run-time commands take effect.
- R8: A write with addr=0, wdata[4]=0, wdata[3]=1 and wdata[1]=1 selects the read-back source by wdata[0]: 0 selects pending and 1 selects in-service. Reads with addr=1 return irq_mask.
- R9: The same command with wdata[6]=1 sets special_mask to wdata[5].
- R10: A write with addr=0, wdata[4:3]=00 and wdata[5]=1 pulses eoi_clear for one cycle. The pulse marks the lowest-numbered set bit of in_service, or is zero if none is set.
- R11: With wdata[5]=0 instead, eoi_clear pulses the bit numbered by wdata[2:0].
- R12: A write strobe held low for several cycles performs its action once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| req_pending | input | 8 | Pending-request register from the core |
| in_service | input | 8 | In-service register from the core |
| cfg_ready | output | 1 | Setup sequence complete |
| irq_mask | output | 8 | Mask register |
| vec_base | output | 5 | Upper bits of the interrupt vector |
| level_mode | output | 1 | 1 = level-triggered requests |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| cascaded | output | 1 | Cascade configuration present |
| special_mask | output | 1 | Special mask mode |
| lowest_line | output | 3 | Line with lowest priority |
| edge_rearm | output | 1 | One-cycle pulse that re-arms edge detection |
| eoi_clear | output | 8 | One-cycle one-hot in-service clear |

## Verification
The assertions check several properties on every cycle. The EOI pulse must be one-hot or empty, and it must never appear before setup completes. The re-arm pulse must last a single cycle and coincide with a cleared mask and special mask. auto_eoi must stay off whenever the fourth word was not requested. The bench scenarios are needed for the word-order decisions: which setup word lands in which field, and whether the third and fourth words are skipped. They also cover strobe gating by select, the single action of a held strobe, and the contents returned by each read-back selection.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_W2   = 3'd1,
      ST_W3   = 3'd2,
      ST_W4   = 3'd3,
      ST_RUN  = 3'd4
   } init_st_t;

   // bit positions decoded by the command logic
   localparam int B_INIT_SEL = 4;
   localparam int B_RSEL_SEL = 3;
   localparam int B_NEED4    = 0;
   localparam int B_SINGLE   = 1;
   localparam int B_LEVEL    = 3;
   localparam int B_AEOI     = 1;
   localparam int B_NONSPEC  = 5;
   localparam int B_SMM_ACT  = 6;
   localparam int B_SMM_VAL  = 5;
   localparam int B_RSEL_ACT = 1;
   localparam int B_RSEL_VAL = 0;
endpackage

// File: rtl/irq_cmd_strobe.sv
module irq_cmd_strobe
   import irq_cmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              hit_init,
   output logic              hit_hi,
   output logic              hit_rsel,
   output logic              hit_eoi
);
   logic wr_act, wr_act_q, fire;

   assign wr_act = !cs_n && !wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_act_q <= 1'b0;
      else        wr_act_q <= wr_act;
   end

   assign fire     = wr_act && !wr_act_q;
   assign hit_init = fire && !addr && wdata[B_INIT_SEL];
   assign hit_hi   = fire && addr;
   assign hit_rsel = fire && !addr && !wdata[B_INIT_SEL] && wdata[B_RSEL_SEL];
   assign hit_eoi  = fire && !addr && !wdata[B_INIT_SEL] && !wdata[B_RSEL_SEL];
endmodule

// File: rtl/irq_cmd_init.sv
module irq_cmd_init
   import irq_cmd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINE_W = 3,
   localparam int VEC_W = DATA_W - LINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_init,
   input  logic              hit_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic              ready,
   output logic [VEC_W-1:0]  vec_base,
   output logic              level_mode,
   output logic              cascaded,
   output logic              auto_eoi,
   output logic              edge_rearm,
   output logic [LINE_W-1:0] lowest_line
);
   init_st_t st, st_nx;
   logic     need4_q;

   always_comb begin
      st_nx = st;
      if (hit_init) st_nx = ST_W2;
      else if (hit_hi) begin
         unique case (st)
            ST_W2:   st_nx = cascaded ? ST_W3 : (need4_q ? ST_W4 : ST_RUN);
            ST_W3:   st_nx = need4_q ? ST_W4 : ST_RUN;
            ST_W4:   st_nx = ST_RUN;
            default: st_nx = st;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         need4_q     <= 1'b0;
         vec_base    <= '0;
         level_mode  <= 1'b0;
         cascaded    <= 1'b0;
         auto_eoi    <= 1'b0;
         edge_rearm  <= 1'b0;
         lowest_line <= LINE_W'((1 << LINE_W) - 1);
      end else begin
         st         <= st_nx;
         edge_rearm <= hit_init;
         if (hit_init) begin
            need4_q     <= wdata[B_NEED4];
            cascaded    <= !wdata[B_SINGLE];
            level_mode  <= wdata[B_LEVEL];
            auto_eoi    <= 1'b0;
            lowest_line <= LINE_W'((1 << LINE_W) - 1);
         end else if (hit_hi) begin
            if (st == ST_W2) vec_base <= wdata[DATA_W-1:LINE_W];
            if (st == ST_W4) auto_eoi <= wdata[B_AEOI];
         end
      end
   end

   assign ready = (st == ST_RUN);

   // R3
   rearm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_rearm |=> !edge_rearm);

   // R6
   aeoi_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && !need4_q) |-> !auto_eoi);
endmodule

// File: rtl/irq_cmd_ops.sv
module irq_cmd_ops
   import irq_cmd_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int DATA_W    = 8,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ready,
   input  logic                 hit_init,
   input  logic                 hit_hi,
   input  logic                 hit_rsel,
   input  logic                 hit_eoi,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_LINES-1:0] in_service,
   output logic [NUM_LINES-1:0] mask,
   output logic                 sel_isr,
   output logic                 special_mask,
   output logic [NUM_LINES-1:0] eoi_clear
);
   logic [NUM_LINES-1:0] top_isr, eoi_nx;

   always_comb begin
      top_isr = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (in_service[i]) top_isr = NUM_LINES'(1) << i;
      end
   end

   always_comb begin
      eoi_nx = '0;
      if (ready && hit_eoi) begin
         if (wdata[B_NONSPEC]) eoi_nx = top_isr;
         else                  eoi_nx = NUM_LINES'(1) << wdata[LINE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask         <= '0;
         sel_isr      <= 1'b0;
         special_mask <= 1'b0;
         eoi_clear    <= '0;
      end else begin
         eoi_clear <= eoi_nx;
         if (hit_init) begin
            mask         <= '0;
            sel_isr      <= 1'b0;
            special_mask <= 1'b0;
         end else if (ready) begin
            if (hit_hi) mask <= wdata[NUM_LINES-1:0];
            if (hit_rsel) begin
               if (wdata[B_RSEL_ACT]) sel_isr      <= wdata[B_RSEL_VAL];
               if (wdata[B_SMM_ACT])  special_mask <= wdata[B_SMM_VAL];
            end
         end
      end
   end

   // R10
   eoi_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eoi_clear));

   // R7
   eoi_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (eoi_clear == '0));
endmodule

// File: rtl/irq_cmd_port.sv
module irq_cmd_port
   import irq_cmd_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int DATA_W    = 8,
   parameter bit READ_REG  = 1'b0,
   localparam int LINE_W   = $clog2(NUM_LINES),
   localparam int VEC_W    = DATA_W - LINE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 wr_n,
   input  logic                 rd_n,
   input  logic                 addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic [NUM_LINES-1:0] req_pending,
   input  logic [NUM_LINES-1:0] in_service,
   output logic                 cfg_ready,
   output logic [NUM_LINES-1:0] irq_mask,
   output logic [VEC_W-1:0]     vec_base,
   output logic                 level_mode,
   output logic                 auto_eoi,
   output logic                 cascaded,
   output logic                 special_mask,
   output logic [LINE_W-1:0]    lowest_line,
   output logic                 edge_rearm,
   output logic [NUM_LINES-1:0] eoi_clear
);
   if (NUM_LINES != DATA_W) begin : g_bad_width
      $error("irq_cmd_port: NUM_LINES must equal DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("irq_cmd_port: DATA_W must be at least 8");
   end

   logic hit_init, hit_hi, hit_rsel, hit_eoi, sel_isr;
   logic [DATA_W-1:0] rd_mux;

   irq_cmd_strobe #(.DATA_W(DATA_W)) u_strobe (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .hit_init(hit_init), .hit_hi(hit_hi),
      .hit_rsel(hit_rsel), .hit_eoi(hit_eoi)
   );

   irq_cmd_init #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_init (
      .clk(clk), .rst_n(rst_n), .hit_init(hit_init), .hit_hi(hit_hi),
      .wdata(wdata), .ready(cfg_ready), .vec_base(vec_base),
      .level_mode(level_mode), .cascaded(cascaded), .auto_eoi(auto_eoi),
      .edge_rearm(edge_rearm), .lowest_line(lowest_line)
   );

   irq_cmd_ops #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_ops (
      .clk(clk), .rst_n(rst_n), .ready(cfg_ready), .hit_init(hit_init),
      .hit_hi(hit_hi), .hit_rsel(hit_rsel), .hit_eoi(hit_eoi),
      .wdata(wdata), .in_service(in_service), .mask(irq_mask),
      .sel_isr(sel_isr), .special_mask(special_mask), .eoi_clear(eoi_clear)
   );

   always_comb begin
      rd_mux = '0;
      if (!cs_n && !rd_n) begin
         if (addr)         rd_mux = DATA_W'(irq_mask);
         else if (sel_isr) rd_mux = DATA_W'(in_service);
         else              rd_mux = DATA_W'(req_pending);
      end
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign rdata = rd_mux;
   end

   // R3
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_rearm |-> (irq_mask == '0 && !special_mask && !cfg_ready));
endmodule

// File: tb/irq_cmd_port_bench.sv
module irq_cmd_port_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, addr = 1'b0;
   logic [7:0] wdata = '0, rdata, req_pending = '0, in_service = '0;
   logic cfg_ready, level_mode, auto_eoi, cascaded, special_mask, edge_rearm;
   logic [7:0] irq_mask, eoi_clear;
   logic [4:0] vec_base;
   logic [2:0] lowest_line;

   always #2 clk = ~clk;

   irq_cmd_port u_irq_cmd_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .req_pending(req_pending),
      .in_service(in_service), .cfg_ready(cfg_ready), .irq_mask(irq_mask),
      .vec_base(vec_base), .level_mode(level_mode), .auto_eoi(auto_eoi),
      .cascaded(cascaded), .special_mask(special_mask),
      .lowest_line(lowest_line), .edge_rearm(edge_rearm), .eoi_clear(eoi_clear)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // model state: 0 idle, 1 w2, 2 w3, 3 w4, 4 run
   int e_st = 0;
   bit e_need4 = 0, e_casc = 0, e_lvl = 0, e_aeoi = 0, e_smm = 0, e_sel = 0;
   logic [7:0] e_mask = '0, e_eoi = '0;
   logic [4:0] e_vec = '0;
   bit e_rearm = 0;
   logic [7:0] got_eoi;
   bit got_rearm;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] low_bit(input logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return 8'(1) << i;
      return 8'h00;
   endfunction

   function automatic int next_after_w2();
      return e_casc ? 2 : (e_need4 ? 3 : 4);
   endfunction

   task automatic model_write(input bit a, input logic [7:0] d);
      e_eoi = '0;
      e_rearm = 0;
      if (!a && d[4]) begin
         e_st = 1; e_need4 = d[0]; e_casc = !d[1]; e_lvl = d[3]; e_aeoi = 0;
         e_mask = '0; e_smm = 0; e_sel = 0; e_rearm = 1;
      end else if (a) begin
         case (e_st)
            1: begin e_vec = d[7:3]; e_st = next_after_w2(); end
            2: e_st = e_need4 ? 3 : 4;
            3: begin e_aeoi = d[1]; e_st = 4; end
            4: e_mask = d;
            default: ;
         endcase
      end else if (e_st == 4) begin
         if (d[3]) begin
            if (d[1]) e_sel = d[0];
            if (d[6]) e_smm = d[5];
         end else begin
            e_eoi = d[5] ? low_bit(in_service) : (8'(1) << d[2:0]);
         end
      end
   endtask

   task automatic full_check();
      chk("R7", "cfg_ready", int'(cfg_ready), int'(e_st == 4));
      chk("R7", "irq_mask", int'(irq_mask), int'(e_mask));
      chk("R4", "vec_base", int'(vec_base), int'(e_vec));
      chk("R4", "level_mode", int'(level_mode), int'(e_lvl));
      chk("R5", "cascaded", int'(cascaded), int'(e_casc));
      chk("R6", "auto_eoi", int'(auto_eoi), int'(e_aeoi));
      chk("R9", "special_mask", int'(special_mask), int'(e_smm));
      chk("R3", "lowest_line", int'(lowest_line), 7);
      chk("R10", "eoi_clear", int'(got_eoi), int'(e_eoi));
      chk("R3", "edge_rearm", int'(got_rearm), int'(e_rearm));
      chk("R3", "edge_rearm after pulse", int'(edge_rearm), 0);
   endtask

   task automatic wr(input bit a, input logic [7:0] d);
      @(negedge clk);
      cs_n = 0; wr_n = 0; addr = a; wdata = d;
      @(negedge clk);
      got_eoi = eoi_clear; got_rearm = edge_rearm;
      cs_n = 1; wr_n = 1;
      @(negedge clk);
      model_write(a, d);
      full_check();
   endtask

   task automatic rd(input bit a, output logic [7:0] v);
      @(negedge clk);
      cs_n = 0; rd_n = 0; addr = a;
      #1 v = rdata;
      cs_n = 1; rd_n = 1;
   endtask

   task automatic rd_check(input bit a, input string req);
      logic [7:0] v, exp;
      rd(a, v);
      exp = a ? e_mask : (e_sel ? in_service : req_pending);
      chk(req, "rdata", int'(v), int'(exp));
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int pulses;
      void'($urandom(32'd1234));
      req_pending = 8'h5A; in_service = 8'h24;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "cfg_ready", int'(cfg_ready), 0);
      chk("R1", "irq_mask", int'(irq_mask), 0);
      chk("R1", "vec_base", int'(vec_base), 0);
      chk("R1", "flags", int'({level_mode, auto_eoi, cascaded, special_mask, edge_rearm}), 0);
      chk("R1", "eoi_clear", int'(eoi_clear), 0);
      chk("R1", "lowest_line", int'(lowest_line), 7);
      rd_check(0, "R1");
      // R7 run-time commands ignored before setup
      wr(0, 8'h20);
      wr(1, 8'hFF);

      // setup: single, need4, edge
      wr(0, 8'h13);
      wr(1, 8'h48);
      chk("R6", "waiting for fourth word", int'(cfg_ready), 0);
      wr(1, 8'h02);
      chk("R6", "auto_eoi", int'(auto_eoi), 1);
      wr(1, 8'hA5);
      rd_check(1, "R8");

      // R2 write and read with select high
      @(negedge clk); wr_n = 0; addr = 1; wdata = 8'h00;
      @(negedge clk); wr_n = 1;
      @(negedge clk);
      chk("R2", "irq_mask unchanged", int'(irq_mask), int'(e_mask));
      rd_n = 0; addr = 1; #1 chk("R2", "rdata idle", int'(rdata), 0); rd_n = 1;

      // R8 read-back selection, R9 special mask
      wr(0, 8'h0B); rd_check(0, "R8");
      wr(0, 8'h08); rd_check(0, "R8 keep");
      wr(0, 8'h68); chk("R9", "special_mask set", int'(special_mask), 1);
      wr(0, 8'h0A); rd_check(0, "R8");
      wr(0, 8'h48); chk("R9", "special_mask clr", int'(special_mask), 0);

      // R10 nonspecific EOI, R11 specific EOI
      in_service = 8'b0110_0100;
      wr(0, 8'h20); chk("R10", "nonspecific", int'(got_eoi), 8'h04);
      in_service = 8'h00;
      wr(0, 8'h20); chk("R10", "empty", int'(got_eoi), 0);
      wr(0, 8'h03); chk("R11", "specific", int'(got_eoi), 8'h08);

      // R12 held strobe acts once
      in_service = 8'h80; pulses = 0;
      @(negedge clk); cs_n = 0; wr_n = 0; addr = 0; wdata = 8'h20;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (eoi_clear != 0) pulses++;
      end
      cs_n = 1; wr_n = 1;
      @(negedge clk);
      chk("R12", "pulse count", pulses, 1);

      // restart: cascaded, level, no fourth word
      wr(0, 8'h18);
      chk("R3", "mask cleared", int'(irq_mask), 0);
      chk("R5", "cascaded", int'(cascaded), 1);
      wr(1, 8'hF8);
      chk("R5", "waiting for third word", int'(cfg_ready), 0);
      wr(1, 8'h04);
      chk("R6", "no fourth word", int'(cfg_ready), 1);
      chk("R6", "auto_eoi off", int'(auto_eoi), 0);

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         bit a;
         logic [7:0] d;
         a = 1'($urandom);
         d = 8'($urandom);
         if (!a && d[4] && ($urandom % 6 != 0)) d[4] = 1'b0;
         req_pending = 8'($urandom);
         in_service = 8'($urandom) & 8'($urandom);
         wr(a, d);
         if (n % 4 == 0) rd_check(1'($urandom), "R8");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule